// File: doc/BRIEF.md
# Interrupt Entry and Power-Mode Sequencer

This block is the control sequencer of a small 8-bit microcontroller core. At every instruction boundary it decides whether to divert execution into an interrupt handler. The core marks a boundary with a retire strobe and decoded indications for the retiring instruction: enable-interrupts, write of the status register, sleep, and watchdog-reset. When the block diverts, it stalls the core. It then hands the two return-address bytes to the stack writer over a valid/ready byte stream. Next it loads the handler vector into the program counter and pulses an acknowledge line back to the requesting peripheral. It owns the global interrupt-enable flag.

Two rules set the timing. First, the instruction that follows an enabling instruction always runs. Second, a sleep instruction parks the core until a request arrives, but only when interrupts were already enabled. A two-bit mode output tells outside logic when the core is asleep and when a watchdog-reset instruction has retired. The return-address stream follows valid/ready rules. A byte is transferred on a rising clock edge where both `push_valid` and `push_ready` are high. While `push_valid` is high and `push_ready` is low, the byte is held unchanged and the sequencer waits, so the stack writer may apply back-pressure for any number of cycles. The remaining pins are plain level or strobe signals.

Top module: `irq_seq`

## Requirements
- R1: Reset is synchronous and active high. After it, `mode` is 2'b00 and `ien` is 0. `stall`, `push_valid`, `pc_load` and every `irq_ack` line are also 0.
- R2: An interrupt is taken only at a retire boundary where `ien` was already 1 before that instruction retired. As a result, after an enabling instruction retires, at least one more instruction retires before entry. `stall` and `push_valid` rise in the cycle after the taking boundary.
- R3: A retiring status-register write loads `ien` from `sreg_ien_bit`, which is bit 7 of the written value. A retiring enable instruction sets `ien` to 1.
- R4: When several requests are pending, the lowest-numbered line is taken.
- R5: The return address is sent as two bytes, most significant first by default. Parameter `MSB_FIRST=0` reverses the order. Each byte is held stable while `push_valid` is high and `push_ready` is low.
- R6: The vector loaded is the interrupt number, or twice the interrupt number when `TWO_WORD_VEC=1`.
- R7: `irq_ack` pulses bit n for exactly one cycle, in the cycle `pc_load` is high. Line 0 is never acknowledged, and no other line pulses.
- R8: Taking an interrupt clears `ien`. The flag reads 0 from the first stalled cycle.
- R9: A retiring sleep instruction with `ien`=1 and no request pending sets `mode` to 2'b01 and holds `stall` high until a request arrives. `mode` returns to 2'b00 in the first cycle of entry. With `ien`=0, a sleep instruction has no effect.
- R10: A retiring watchdog-reset instruction makes `mode` 2'b10 for exactly the next cycle.
- R11: Retire strobes are ignored while `stall` is high.
- R12: Requests have no effect while `ien` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retire | input | 1 | Instruction boundary strobe |
| op_sei | input | 1 | Retiring instruction enables interrupts |
| op_sreg_wr | input | 1 | Retiring instruction writes the status register |
| sreg_ien_bit | input | 1 | Bit 7 of the status value being written |
| op_sleep | input | 1 | Retiring instruction is sleep |
| op_wdr | input | 1 | Retiring instruction is watchdog-reset |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| ret_pc | input | PC_W | Address of the next instruction to run |
| push_valid | output | 1 | Return-address byte available |
| push_ready | input | 1 | Stack writer accepts the byte |
| push_data | output | 8 | Return-address byte |
| pc_load | output | 1 | Load vector into program counter |
| pc_vec | output | PC_W | Handler vector address |
| irq_ack | output | NUM_IRQ | One-hot acknowledge pulse |
| ien | output | 1 | Global interrupt-enable flag |
| mode | output | 2 | 00 run, 01 sleep, 10 watchdog-reset pulse |
| stall | output | 1 | Core must hold its instruction flow |

## Verification
Every cycle, the assertions check the following. A boundary with the flag clear never starts a push. Taking an interrupt leaves the flag cleared. A held byte stays stable under back-pressure. Acknowledges are one-hot, never on line 0, and only alongside a vector load. The sleep mode always comes with a stall. A retired watchdog-reset always shows the 2'b10 mode. Other behaviours need a reference model of the instruction stream, so only the bench's scenarios can show them. These are the one-instruction delay after an enable, the choice among simultaneous requests, the exact byte order and vector value, wake timing, and that stray strobes during a stall change nothing.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_PUSH_A = 3'd2,
    ST_PUSH_B = 3'd3,
    ST_LOAD   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_IRQ = 8,
  parameter int ID_W    = 3
) (
  input  logic [NUM_IRQ-1:0] req_i,
  output logic               any_o,
  output logic [ID_W-1:0]    id_o
);
  // lowest-numbered pending line wins (R4)
  always_comb begin
    any_o = |req_i;
    id_o  = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = ID_W'(i);
    end
  end
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic sei_i,
  input  logic sreg_wr_i,
  input  logic sreg_bit_i,
  input  logic take_i,
  output logic ien_o
);
  logic ien_q;

  always_ff @(posedge clk) begin
    if (rst)                   ien_q <= 1'b0;
    else if (take_i)           ien_q <= 1'b0;
    else if (step_i && sei_i)  ien_q <= 1'b1;
    else if (step_i && sreg_wr_i) ien_q <= sreg_bit_i;
  end

  assign ien_o = ien_q;

  assert_take_clears_R8: assert property (@(posedge clk) disable iff (rst)
    take_i |=> !ien_o);

  // R11: without an accepted boundary or an entry, the flag holds
  assert_flag_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !take_i) |=> $stable(ien_o));
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
  import irq_seq_pkg::*;
#(
  parameter int NUM_IRQ      = 8,
  parameter int ID_W         = 3,
  parameter int PC_W         = 16,
  parameter bit MSB_FIRST    = 1'b1,
  parameter bit TWO_WORD_VEC = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               retire_i,
  input  logic               sleep_i,
  input  logic               wdr_i,
  input  logic               ien_i,
  input  logic               any_i,
  input  logic [ID_W-1:0]    id_i,
  input  logic [PC_W-1:0]    ret_pc_i,
  input  logic               push_ready_i,
  output logic               step_o,
  output logic               take_o,
  output logic               push_valid_o,
  output logic [7:0]         push_data_o,
  output logic               pc_load_o,
  output logic [PC_W-1:0]    pc_vec_o,
  output logic [NUM_IRQ-1:0] ack_o,
  output logic [1:0]         mode_o,
  output logic               stall_o
);
  localparam int RET_W = 16;

  seq_state_e          state_q, state_d;
  logic [ID_W-1:0]     id_q;
  logic [PC_W-1:0]     ret_q;
  logic                wdr_q;
  logic [RET_W-1:0]    ret_wide;
  logic [7:0]          byte_first, byte_second;
  logic [PC_W-1:0]     vec_w;

  assign step_o = retire_i && (state_q == ST_RUN);
  assign take_o = (step_o && ien_i && any_i) || ((state_q == ST_SLEEP) && any_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (take_o)                          state_d = ST_PUSH_A;
        else if (step_o && sleep_i && ien_i) state_d = ST_SLEEP;
      end
      ST_SLEEP:  if (any_i)        state_d = ST_PUSH_A;
      ST_PUSH_A: if (push_ready_i) state_d = ST_PUSH_B;
      ST_PUSH_B: if (push_ready_i) state_d = ST_LOAD;
      ST_LOAD:                     state_d = ST_RUN;
      default:                     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      id_q    <= '0;
      ret_q   <= '0;
      wdr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wdr_q   <= step_o && wdr_i;
      if (take_o) begin
        id_q  <= id_i;
        ret_q <= ret_pc_i;
      end
    end
  end

  assign ret_wide = RET_W'(ret_q);

  generate
    if (MSB_FIRST) begin : g_msb
      assign byte_first  = ret_wide[15:8];
      assign byte_second = ret_wide[7:0];
    end else begin : g_lsb
      assign byte_first  = ret_wide[7:0];
      assign byte_second = ret_wide[15:8];
    end
  endgenerate

  generate
    if (TWO_WORD_VEC) begin : g_two
      assign vec_w = PC_W'({id_q, 1'b0});
    end else begin : g_one
      assign vec_w = PC_W'(id_q);
    end
  endgenerate

  generate
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ack
      if (g == 0) begin : g_none
        assign ack_o[g] = 1'b0;
      end else begin : g_line
        assign ack_o[g] = (state_q == ST_LOAD) && (id_q == ID_W'(g));
      end
    end
  endgenerate

  assign push_valid_o = (state_q == ST_PUSH_A) || (state_q == ST_PUSH_B);
  assign push_data_o  = (state_q == ST_PUSH_B) ? byte_second : byte_first;
  assign pc_load_o    = (state_q == ST_LOAD);
  assign pc_vec_o     = vec_w;
  assign stall_o      = (state_q != ST_RUN);
  assign mode_o       = (state_q == ST_SLEEP) ? 2'b01 : (wdr_q ? 2'b10 : 2'b00);

  assert_push_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (push_valid_o && !push_ready_i) |=> (push_valid_o && $stable(push_data_o)));

  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_o) && !ack_o[0]);

  assert_ack_with_load_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_o != '0) |-> pc_load_o);

  assert_load_single_R7: assert property (@(posedge clk) disable iff (rst)
    pc_load_o |=> !pc_load_o);

  assert_wdr_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (step_o && wdr_i && !sleep_i) |=> (mode_o == 2'b10));
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int NUM_IRQ      = 8,
  parameter int PC_W         = 16,
  parameter bit MSB_FIRST    = 1'b1,
  parameter bit TWO_WORD_VEC = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               retire,
  input  logic               op_sei,
  input  logic               op_sreg_wr,
  input  logic               sreg_ien_bit,
  input  logic               op_sleep,
  input  logic               op_wdr,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [PC_W-1:0]    ret_pc,
  output logic               push_valid,
  input  logic               push_ready,
  output logic [7:0]         push_data,
  output logic               pc_load,
  output logic [PC_W-1:0]    pc_vec,
  output logic [NUM_IRQ-1:0] irq_ack,
  output logic               ien,
  output logic [1:0]         mode,
  output logic               stall
);
  localparam int ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic            any_w;
  logic [ID_W-1:0] id_w;
  logic            step_w;
  logic            take_w;

  irq_pick #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_pick (
    .req_i (irq_req),
    .any_o (any_w),
    .id_o  (id_w)
  );

  irq_flag u_flag (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_w),
    .sei_i      (op_sei),
    .sreg_wr_i  (op_sreg_wr),
    .sreg_bit_i (sreg_ien_bit),
    .take_i     (take_w),
    .ien_o      (ien)
  );

  irq_fsm #(
    .NUM_IRQ      (NUM_IRQ),
    .ID_W         (ID_W),
    .PC_W         (PC_W),
    .MSB_FIRST    (MSB_FIRST),
    .TWO_WORD_VEC (TWO_WORD_VEC)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .retire_i     (retire),
    .sleep_i      (op_sleep),
    .wdr_i        (op_wdr),
    .ien_i        (ien),
    .any_i        (any_w),
    .id_i         (id_w),
    .ret_pc_i     (ret_pc),
    .push_ready_i (push_ready),
    .step_o       (step_w),
    .take_o       (take_w),
    .push_valid_o (push_valid),
    .push_data_o  (push_data),
    .pc_load_o    (pc_load),
    .pc_vec_o     (pc_vec),
    .ack_o        (irq_ack),
    .mode_o       (mode),
    .stall_o      (stall)
  );

  // R2 and R12: a boundary seen with the flag clear never starts entry
  assert_holdoff_R2: assert property (@(posedge clk) disable iff (rst)
    (retire && !stall && !ien) |=> !push_valid);

  assert_sleep_stalls_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> stall);
endmodule

// File: tb/irq_seq_test.sv
module irq_seq_test;
  localparam int N  = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          retire = 1'b0, op_sei = 1'b0, op_sreg_wr = 1'b0, sreg_ien_bit = 1'b0;
  logic          op_sleep = 1'b0, op_wdr = 1'b0, push_ready = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic [PW-1:0] ret_pc = '0;
  logic          push_valid, pc_load, ien, stall;
  logic [7:0]    push_data;
  logic [PW-1:0] pc_vec;
  logic [N-1:0]  irq_ack;
  logic [1:0]    mode;

  always #4 clk = ~clk;

  irq_seq #(.NUM_IRQ(N), .PC_W(PW)) uut (
    .clk(clk), .rst(rst), .retire(retire), .op_sei(op_sei), .op_sreg_wr(op_sreg_wr),
    .sreg_ien_bit(sreg_ien_bit), .op_sleep(op_sleep), .op_wdr(op_wdr),
    .irq_req(irq_req), .ret_pc(ret_pc), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pc_load(pc_load), .pc_vec(pc_vec), .irq_ack(irq_ack),
    .ien(ien), .mode(mode), .stall(stall)
  );

  int checks = 0;
  int fails  = 0;
  bit ien_m  = 1'b0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick_low(input logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic int ack_of(input int id);
    return (id == 0) ? 0 : (1 << id);
  endfunction

  task automatic run_entry(input int id, input logic [PW-1:0] ret);
    logic [7:0] e;
    bit acc;
    chk(stall == 1'b1, "R11 stall during entry", int'(stall), 1);
    chk(ien == 1'b0, "R8 flag cleared", int'(ien), 0);
    for (int b = 0; b < 2; b++) begin
      acc = 1'b0;
      e = (b == 0) ? ret[15:8] : ret[7:0];
      while (!acc) begin
        chk(push_valid == 1'b1, "R5 valid", int'(push_valid), 1);
        chk(push_data == e, "R5 byte order", int'(push_data), int'(e));
        chk(pc_load == 1'b0 && irq_ack == '0, "R7 no early ack", int'(irq_ack), 0);
        push_ready = (($urandom % 3) != 0);
        acc = push_ready;
        @(negedge clk);
      end
    end
    push_ready = 1'b0;
    chk(pc_load == 1'b1, "R7 load", int'(pc_load), 1);
    chk(pc_vec == PW'(id), "R6 vector", int'(pc_vec), id);
    chk(int'(irq_ack) == ack_of(id), "R7 ack line", int'(irq_ack), ack_of(id));
    chk(push_valid == 1'b0, "R5 stream done", int'(push_valid), 0);
    @(negedge clk);
    chk(pc_load == 1'b0 && irq_ack == '0 && stall == 1'b0, "R7 single pulse",
        int'(irq_ack), 0);
  endtask

  task automatic sleep_phase(input logic [PW-1:0] ret);
    int id;
    logic [N-1:0] r;
    for (int k = 0; k < 3; k++) begin
      retire = 1'b1; op_sreg_wr = 1'b1; sreg_ien_bit = 1'b0;
      @(negedge clk);
      retire = 1'b0; op_sreg_wr = 1'b0;
      chk(mode == 2'b01 && stall == 1'b1, "R9 asleep", int'(mode), 1);
      chk(ien == 1'b1, "R11 retire ignored while stalled", int'(ien), 1);
    end
    r = N'($urandom);
    if (r == '0) r = N'(1 << 3);
    irq_req = r;
    id = pick_low(r);
    @(negedge clk);
    chk(mode == 2'b00, "R9 wake mode", int'(mode), 0);
    ien_m = 1'b0;
    run_entry(id, ret);
  endtask

  task automatic instr(input bit s, input bit w, input bit wb, input bit sl, input bit wd);
    bit take, sleeping;
    int id;
    logic [PW-1:0] rp;
    rp = PW'($urandom);
    ret_pc = rp;
    retire = 1'b1; op_sei = s; op_sreg_wr = w; sreg_ien_bit = wb;
    op_sleep = sl; op_wdr = wd;
    take = ien_m && (irq_req != '0);
    id = pick_low(irq_req);
    sleeping = !take && sl && ien_m;
    if (take) ien_m = 1'b0;
    else if (s) ien_m = 1'b1;
    else if (w) ien_m = wb;
    @(negedge clk);
    retire = 1'b0; op_sei = 1'b0; op_sreg_wr = 1'b0; op_sleep = 1'b0; op_wdr = 1'b0;
    if (wd) chk(mode == 2'b10, "R10 wdr mode", int'(mode), 2);
    else    chk(mode == (sleeping ? 2'b01 : 2'b00), "R9 mode", int'(mode), sleeping ? 1 : 0);
    chk(ien == ien_m, "R3 flag value", int'(ien), int'(ien_m));
    chk(stall == (take || sleeping), "R2 entry boundary", int'(stall), int'(take || sleeping));
    if (take) run_entry(id, rp);
    else if (sleeping) sleep_phase(rp);
    else if (wd) begin
      @(negedge clk);
      chk(mode == 2'b00, "R10 single cycle", int'(mode), 0);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int kind;
    logic [N-1:0] r;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(stall == 0 && push_valid == 0 && pc_load == 0 && irq_ack == '0 && mode == 2'b00
        && ien == 0, "R1 during reset", int'(mode), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(stall == 0 && push_valid == 0 && ien == 0 && mode == 2'b00, "R1 after reset",
        int'(ien), 0);

    // R12: requests with flag clear
    irq_req = 8'h06;
    instr(0, 0, 0, 0, 0);
    instr(0, 0, 0, 0, 0);
    chk(stall == 0 && push_valid == 0, "R12 requests ignored", int'(stall), 0);
    // R2: enable with request pending; next boundary takes line 1 (R4)
    instr(1, 0, 0, 0, 0);
    chk(stall == 0 && ien == 1, "R2 instruction after enable runs", int'(stall), 0);
    instr(0, 0, 0, 0, 0);
    // R3 via status write, then line 0 taken with no acknowledge (R7)
    irq_req = 8'h81;
    instr(0, 1, 1, 0, 0);
    instr(0, 0, 0, 0, 0);
    irq_req = '0;
    instr(1, 0, 0, 0, 0);
    instr(0, 1, 0, 0, 0);
    chk(ien == 0, "R3 status write clears", int'(ien), 0);
    instr(0, 0, 0, 0, 1);
    instr(0, 0, 0, 1, 0);
    chk(mode == 2'b00 && stall == 0, "R9 sleep ignored with flag clear", int'(mode), 0);
    instr(1, 0, 0, 0, 0);
    instr(0, 0, 0, 1, 0);

    for (int n = 0; n < 400; n++) begin
      if (($urandom % 6) == 0) begin
        r = N'($urandom & $urandom & $urandom);
        irq_req = r;
      end
      kind = $urandom % 8;
      case (kind)
        0: instr(1, 0, 0, 0, 0);
        1: instr(0, 1, 1'($urandom), 0, 0);
        2: instr(0, 0, 0, 1, 0);
        3: instr(0, 0, 0, 0, 1);
        default: instr(0, 0, 0, 0, 0);
      endcase
    end
    done = 1'b1;
    finish_run();
  end
endmodule